// File: doc/BRIEF.md
# SMRAM Access Control and TSEG Decoder

This block decides where a processor memory access is routed when system-management memory is involved. It holds the configuration state for that memory: a byte-wide main control register, a byte-wide extended control register and a 16-bit extended-size register. Each accepted access carries an address and a flag that says whether the processor is in system-management mode (SMM). The block returns one registered routing code per access. The code says whether the access reaches DRAM, goes to the PCI/video path, is swallowed by a hole that reads all ones and discards writes, or is not decoded here at all.

Three address windows are decoded. The first is the legacy video area at 0xA0000–0xBFFFF. The second is a 128 KiB alias at 0xFEDA0000 that maps onto the same DRAM as the legacy area. The third is a segment of programmable size that ends at the top of low memory, a static input. A lock bit makes the configuration tamper-proof until the next reset.

Accesses enter on a valid/ready handshake and results leave on a valid/ready handshake. The rules are as follows:
- An access is accepted when `acc_valid` and `acc_ready` are both high.
- `acc_ready` is high whenever the result register is empty or the consumer asserts `rt_ready`.
- While `rt_valid` is high and `rt_ready` is low, the held result does not change and no new access is taken.

The configuration port is plain: a write happens in the cycle `cfg_we` is high. Reads are combinational.

Top module: `smram_route_ctrl`

## Requirements
- R1: After reset the three registers read as follows: select 0 (main control) reads 0x02, select 1 (extended control) reads 0x38, and select 2 (extended size) reads 0xFFFF when the parameter `EXT_MB` is non-zero and 0 otherwise. The output `rt_valid` is 0 and `rt_route` is 0.
- R2: Register selects are 0 = main control, 1 = extended control, 2 = extended size and 3 = none. Select 3 always reads 0 and a write to it changes no register. While unlocked, main-control bits 6 (open), 5 (spare), 4 (lock) and 3 (global enable) are writable and the other bits keep their reset value. In extended control, bits 7 (high enable), 2:1 (size code) and 0 (segment enable) are writable.
- R3: A write that leaves main-control bit 4 set also clears bit 6 in that same write. From then until reset, only main-control bit 5 is writable and extended control is not writable at all.
- R4: Route codes are 0 = not decoded, 1 = DRAM, 2 = PCI/video path, 3 = hole. A normal-mode access in 0xA0000–0xBFFFF routes to 1 only when open = 1 and high enable = 0, and otherwise routes to 2.
- R5: A normal-mode access in 0xFEDA0000–0xFEDBFFFF routes to 1 when open = 1 and high enable = 1, and otherwise routes to 0.
- R6: When global enable is set, an SMM access in the legacy range routes to 1 if high enable = 0. Likewise, an SMM access in the high alias routes to 1 if high enable = 1. In every other case an SMM access in these two ranges gets the normal-mode route.
- R7: The segment size is 0 when the segment enable is 0. Otherwise size codes 0, 1 and 2 select 1, 2 and 8 MiB, and code 3 selects `EXT_MB` MiB.
- R8: The segment covers the range from max(top − size, 0) up to, but not including, top. In it, a normal-mode access routes to 3 and an SMM access routes to 1. An address covered neither by the segment nor by the legacy and alias ranges routes to 0. The legacy and alias ranges take precedence over the segment.
- R9: Writing 0xFFFF to the extended-size register makes it read back `EXT_MB` when `EXT_MB` is non-zero. Any other written value reads back unchanged.
- R10: The route for an accepted access uses the register contents from before the accepting edge. A configuration write in the same cycle first affects accesses accepted one cycle later. While a result is stalled, `rt_valid` and `rt_route` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wsel | input | 2 | Register select for writes |
| cfg_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| cfg_rsel | input | 2 | Register select for reads |
| cfg_rdata | output | 16 | Read data for `cfg_rsel` |
| tolm | input | ADDR_W | Top of low memory (static) |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Access accepted this cycle if valid |
| acc_addr | input | ADDR_W | Access byte address |
| acc_smm | input | 1 | Access is made in system-management mode |
| rt_valid | output | 1 | Route result present |
| rt_ready | input | 1 | Consumer takes the result |
| rt_route | output | 2 | Route code (see R4) |

## Verification
The locked state is the hardest situation to reach and to leave. Software cannot clear the lock, so every lock scenario ends in a reset issued in the middle of the run, and the bench then shows the block fully writable again. While locked, the stimulus retries writes to every register and pattern, and checks that open stays clear and that the legacy range stays on the PCI path. The segment boundaries are driven at base − 1, base, top − 1 and top for every size code. A small top forces the clamp to address zero. A write issued during a stalled output shows that the held result does not change.

// File: rtl/smram_pkg.sv
package smram_pkg;

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_RAM  = 2'd1,
    RT_PCI  = 2'd2,
    RT_HOLE = 2'd3
  } route_e;

  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_EXT = 2'd1;
  localparam logic [1:0] SEL_ESZ = 2'd2;

  // main control bit positions
  localparam int CTL_OPEN = 6;
  localparam int CTL_LOCK = 4;
  localparam int CTL_GEN  = 3;
  // extended control bit positions
  localparam int EXT_HIGH = 7;
  localparam int EXT_SZ_L = 1;
  localparam int EXT_TEN  = 0;

  localparam logic [7:0] CTL_RST      = 8'h02;
  localparam logic [7:0] EXT_RST      = 8'h38;
  localparam logic [7:0] CTL_WM_OPEN  = 8'h78;
  localparam logic [7:0] CTL_WM_LOCK  = 8'h20;
  localparam logic [7:0] EXT_WM_OPEN  = 8'h87;
  localparam logic [15:0] ESZ_QUERY   = 16'hFFFF;

  localparam logic [31:0] LEG_LO  = 32'h000A_0000;
  localparam logic [31:0] LEG_HI  = 32'h000B_FFFF;
  localparam logic [31:0] HIA_LO  = 32'hFEDA_0000;
  localparam logic [31:0] HIA_HI  = 32'hFEDB_FFFF;

endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
  import smram_pkg::*;
#(
  parameter int unsigned EXT_MB = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [1:0]  wsel,
  input  logic [15:0] wdata,
  input  logic [1:0]  rsel,
  output logic [15:0] rdata,
  output logic [7:0]  ctl_q,
  output logic [7:0]  ext_q,
  output logic [15:0] esz_q
);

  localparam logic [15:0] EXT_MB16 = 16'(EXT_MB);
  localparam logic [15:0] ESZ_RST  = (EXT_MB > 0) ? ESZ_QUERY : 16'h0000;

  logic       locked;
  logic [7:0] ctl_wm, ext_wm, ctl_nxt, ext_nxt;
  logic [15:0] esz_nxt;

  assign locked = ctl_q[CTL_LOCK];
  assign ctl_wm = locked ? CTL_WM_LOCK : CTL_WM_OPEN;
  assign ext_wm = locked ? 8'h00 : EXT_WM_OPEN;

  always_comb begin
    ctl_nxt = (ctl_q & ~ctl_wm) | (wdata[7:0] & ctl_wm);
    if (ctl_nxt[CTL_LOCK]) ctl_nxt[CTL_OPEN] = 1'b0;
    ext_nxt = (ext_q & ~ext_wm) | (wdata[7:0] & ext_wm);
    if ((EXT_MB > 0) && (wdata == ESZ_QUERY)) esz_nxt = EXT_MB16;
    else esz_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      ext_q <= EXT_RST;
      esz_q <= ESZ_RST;
    end else if (we) begin
      case (wsel)
        SEL_CTL: ctl_q <= ctl_nxt;
        SEL_EXT: ext_q <= ext_nxt;
        SEL_ESZ: esz_q <= esz_nxt;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rsel)
      SEL_CTL: rdata = {8'h00, ctl_q};
      SEL_EXT: rdata = {8'h00, ext_q};
      SEL_ESZ: rdata = esz_q;
      default: rdata = 16'h0000;
    endcase
  end

endmodule

// File: rtl/smram_tseg_win.sv
module smram_tseg_win
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int unsigned EXT_MB = 16
) (
  input  logic              seg_en,
  input  logic [1:0]        seg_code,
  input  logic [ADDR_W-1:0] tolm,
  output logic              seg_on,
  output logic [ADDR_W-1:0] seg_base
);

  localparam int WIDE = ADDR_W + 16;
  localparam logic [15:0] EXT_MB16 = 16'(EXT_MB);

  logic [15:0]     mbytes;
  logic [WIDE-1:0] size_b;
  logic [WIDE-1:0] tolm_w;
  logic            clamp;

  always_comb begin
    case (seg_code)
      2'd0:    mbytes = 16'd1;
      2'd1:    mbytes = 16'd2;
      2'd2:    mbytes = 16'd8;
      default: mbytes = EXT_MB16;
    endcase
  end

  assign size_b   = WIDE'({mbytes, 20'd0});
  assign tolm_w   = WIDE'(tolm);
  assign clamp    = size_b >= tolm_w;
  assign seg_on   = seg_en && (mbytes != 16'd0);
  assign seg_base = clamp ? '0 : tolm - size_b[ADDR_W-1:0];

endmodule

// File: rtl/smram_route_dec.sv
module smram_route_dec
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              open_bit,
  input  logic              gen_bit,
  input  logic              high_bit,
  input  logic              seg_on,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] tolm,
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  output route_e            route
);

  logic in_leg, in_hia, in_seg;

  assign in_leg = (addr >= ADDR_W'(LEG_LO)) && (addr <= ADDR_W'(LEG_HI));
  assign in_hia = (addr >= ADDR_W'(HIA_LO)) && (addr <= ADDR_W'(HIA_HI));
  assign in_seg = seg_on && (addr >= seg_base) && (addr < tolm);

  always_comb begin
    route = RT_NONE;
    if (in_leg) begin
      if (smm && gen_bit && !high_bit) route = RT_RAM;
      else if (open_bit && !high_bit)  route = RT_RAM;
      else                             route = RT_PCI;
    end else if (in_hia) begin
      if (smm && gen_bit && high_bit)  route = RT_RAM;
      else if (open_bit && high_bit)   route = RT_RAM;
      else                             route = RT_NONE;
    end else if (in_seg) begin
      route = smm ? RT_RAM : RT_HOLE;
    end
  end

endmodule

// File: rtl/smram_route_ctrl.sv
module smram_route_ctrl
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int unsigned EXT_MB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_wsel,
  input  logic [15:0]       cfg_wdata,
  input  logic [1:0]        cfg_rsel,
  output logic [15:0]       cfg_rdata,
  input  logic [ADDR_W-1:0] tolm,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_smm,
  output logic              rt_valid,
  input  logic              rt_ready,
  output logic [1:0]        rt_route
);

  logic [7:0]        ctl_q, ext_q;
  logic [15:0]       esz_q;
  logic              seg_on;
  logic [ADDR_W-1:0] seg_base;
  route_e            route_d, route_q;
  logic              valid_q;

  smram_cfg_regs #(.EXT_MB(EXT_MB)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wsel  (cfg_wsel),
    .wdata (cfg_wdata),
    .rsel  (cfg_rsel),
    .rdata (cfg_rdata),
    .ctl_q (ctl_q),
    .ext_q (ext_q),
    .esz_q (esz_q)
  );

  smram_tseg_win #(.ADDR_W(ADDR_W), .EXT_MB(EXT_MB)) u_seg (
    .seg_en   (ext_q[EXT_TEN]),
    .seg_code (ext_q[EXT_SZ_L+1:EXT_SZ_L]),
    .tolm     (tolm),
    .seg_on   (seg_on),
    .seg_base (seg_base)
  );

  smram_route_dec #(.ADDR_W(ADDR_W)) u_dec (
    .open_bit (ctl_q[CTL_OPEN]),
    .gen_bit  (ctl_q[CTL_GEN]),
    .high_bit (ext_q[EXT_HIGH]),
    .seg_on   (seg_on),
    .seg_base (seg_base),
    .tolm     (tolm),
    .addr     (acc_addr),
    .smm      (acc_smm),
    .route    (route_d)
  );

  assign acc_ready = !valid_q || rt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      route_q <= RT_NONE;
    end else if (acc_ready) begin
      valid_q <= acc_valid;
      if (acc_valid) route_q <= route_d;
    end
  end

  assign rt_valid = valid_q;
  assign rt_route = route_q;

endmodule

// File: rtl/smram_route_chk.sv
module smram_route_chk #(
  parameter int ADDR_W = 32,
  parameter int unsigned EXT_MB = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_wsel,
  input logic [15:0]       cfg_wdata,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_smm,
  input logic              rt_valid,
  input logic              rt_ready,
  input logic [1:0]        rt_route,
  input logic [7:0]        ctl_q,
  input logic [7:0]        ext_q,
  input logic [15:0]       esz_q
);

  logic take, leg;
  assign take = acc_valid && acc_ready;
  assign leg  = (acc_addr >= ADDR_W'(32'hA0000)) && (acc_addr <= ADDR_W'(32'hBFFFF));

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4] |=> ctl_q[4]);
  // R3
  lock_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4] |-> !ctl_q[6]);
  // R3
  lock_ext_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4] |=> $stable(ext_q));
  // R2
  other_sel_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wsel != 2'd0) |=> $stable(ctl_q));
  // R4
  closed_leg_pci_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !acc_smm && leg && !ctl_q[6]) |=> (rt_route == 2'd2));
  // R8
  smm_no_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && acc_smm) |=> (rt_route != 2'd3));
  // R9
  esz_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((EXT_MB > 0) && cfg_we && cfg_wsel == 2'd2 && cfg_wdata == 16'hFFFF)
      |=> (esz_q == 16'(EXT_MB)));
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && !rt_ready) |=> (rt_valid && $stable(rt_route)));

endmodule

bind smram_route_ctrl smram_route_chk #(.ADDR_W(ADDR_W), .EXT_MB(EXT_MB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wsel  (cfg_wsel),
  .cfg_wdata (cfg_wdata),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .acc_addr  (acc_addr),
  .acc_smm   (acc_smm),
  .rt_valid  (rt_valid),
  .rt_ready  (rt_ready),
  .rt_route  (rt_route),
  .ctl_q     (ctl_q),
  .ext_q     (ext_q),
  .esz_q     (esz_q)
);

// File: tb/test_smram_route_ctrl.sv
`timescale 1ns/1ps
module test_smram_route_ctrl;

  localparam int ADDR_W = 32;
  localparam int unsigned EXT_MB = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_wsel = 2'd0;
  logic [15:0]       cfg_wdata = 16'd0;
  logic [1:0]        cfg_rsel = 2'd0;
  logic [15:0]       cfg_rdata;
  logic [ADDR_W-1:0] tolm = 32'h7000_0000;
  logic              acc_valid = 1'b0;
  logic              acc_ready;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic              acc_smm = 1'b0;
  logic              rt_valid;
  logic              rt_ready = 1'b1;
  logic [1:0]        rt_route;

  smram_route_ctrl #(.ADDR_W(ADDR_W), .EXT_MB(EXT_MB)) i_smram_route_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .tolm(tolm), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_smm(acc_smm), .rt_valid(rt_valid),
    .rt_ready(rt_ready), .rt_route(rt_route)
  );

  always #2.5 clk = ~clk;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_ctl, m_ext, m_esz, m_v, m_rt;

  function automatic int ref_route(int c, int e, longint a, bit s, longint t);
    bit opn, gen, hi, on;
    longint sz, base;
    opn = c[6]; gen = c[3]; hi = e[7];
    case ((e >> 1) & 3)
      0: sz = 1;
      1: sz = 2;
      2: sz = 8;
      default: sz = EXT_MB;
    endcase
    sz = sz * 64'd1048576;
    on = e[0] && (sz != 0);
    base = (sz >= t) ? 0 : t - sz;
    if (a >= 64'hA0000 && a <= 64'hBFFFF) begin
      if (s && gen && !hi) return 1;
      return (opn && !hi) ? 1 : 2;
    end
    if (a >= 64'hFEDA0000 && a <= 64'hFEDBFFFF) begin
      if (s && gen && hi) return 1;
      return (opn && hi) ? 1 : 0;
    end
    if (on && a >= base && a < t) return s ? 1 : 3;
    return 0;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    int mask, nv, exp_rd;
    @(posedge clk);
    #1;
    if (!rst_n) begin
      m_ctl = 'h02; m_ext = 'h38; m_esz = (EXT_MB > 0) ? 'hFFFF : 0;
      m_v = 0; m_rt = 0;
    end else begin
      if (!m_v || rt_ready) begin
        m_v = acc_valid;
        if (acc_valid) m_rt = ref_route(m_ctl, m_ext, longint'(acc_addr), acc_smm, longint'(tolm));
      end
      if (cfg_we) begin
        case (cfg_wsel)
          2'd0: begin
            mask = m_ctl[4] ? 'h20 : 'h78;
            nv = (m_ctl & ~mask & 'hFF) | (cfg_wdata & mask);
            if (nv[4]) nv = nv & ~'h40;
            m_ctl = nv;
          end
          2'd1: begin
            mask = m_ctl[4] ? 0 : 'h87;
            m_ext = (m_ext & ~mask & 'hFF) | (cfg_wdata & mask);
          end
          2'd2: m_esz = (EXT_MB > 0 && cfg_wdata == 16'hFFFF) ? int'(EXT_MB) : int'(cfg_wdata);
          default: ;
        endcase
      end
    end
    case (cfg_rsel)
      2'd0: exp_rd = m_ctl;
      2'd1: exp_rd = m_ext;
      2'd2: exp_rd = m_esz;
      default: exp_rd = 0;
    endcase
    chk("rt_valid", int'(rt_valid), m_v);
    chk("rt_route", int'(rt_route), m_rt);
    chk($sformatf("cfg_rdata sel%0d", cfg_rsel), int'(cfg_rdata), exp_rd);
    chk("acc_ready", int'(acc_ready), (!m_v || rt_ready) ? 1 : 0);
    cfg_rsel = cfg_rsel + 2'd1;
  endtask

  task automatic wr(int sel, int data);
    cfg_we = 1'b1; cfg_wsel = 2'(sel); cfg_wdata = 16'(data);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic acc(longint a, bit s);
    acc_valid = 1'b1; acc_addr = ADDR_W'(a); acc_smm = s;
    tick();
    acc_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  longint leg_pts [4] = '{64'h9FFFF, 64'hA0000, 64'hBFFFF, 64'hC0000};
  longint hia_pts [3] = '{64'hFED9FFFF, 64'hFEDA0000, 64'hFEDBFFFF};

  initial begin
    // R1: reset state
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R2: write masks, select 3 ignored
    cur_req = "R2";
    wr(0, 'hEF); idle(3);
    wr(1, 'hFF); idle(3);
    wr(3, 'hFFFF); idle(4);
    wr(0, 'h00); wr(1, 'h00); idle(3);

    // R4 R5 R6: legacy and alias routing across open/high/global
    for (int o = 0; o < 2; o++)
      for (int h = 0; h < 2; h++)
        for (int g = 0; g < 2; g++) begin
          cur_req = "R4";
          wr(0, (o << 6) | (g << 3));
          wr(1, h << 7);
          for (int s = 0; s < 2; s++) begin
            cur_req = s ? "R6" : "R4";
            foreach (leg_pts[k]) acc(leg_pts[k], s);
            cur_req = s ? "R6" : "R5";
            foreach (hia_pts[k]) acc(hia_pts[k], s);
          end
        end
    idle(1);

    // R7 R8: segment sizes and edges
    for (int sc = 0; sc < 4; sc++)
      for (int en = 0; en < 2; en++) begin
        longint sz, t;
        cur_req = "R7";
        wr(1, (sc << 1) | en);
        t = longint'(tolm);
        sz = (sc == 0) ? 1 : (sc == 1) ? 2 : (sc == 2) ? 8 : EXT_MB;
        sz = sz * 64'd1048576;
        cur_req = "R8";
        for (int s = 0; s < 2; s++) begin
          acc(t - sz - 1, s); acc(t - sz, s); acc(t - 1, s); acc(t, s);
          acc(t - 64'h100000 - 1, s);
        end
      end
    // R8: clamp with a small top of low memory, legacy precedence
    cur_req = "R8";
    tolm = 32'h0040_0000;
    wr(1, 'h05);
    for (int s = 0; s < 2; s++) begin
      acc(0, s); acc(64'h3FFFFF, s); acc(64'h400000, s); acc(64'hA0000, s);
    end
    tolm = 32'h7000_0000;
    idle(2);

    // R9: extended size register
    cur_req = "R9";
    wr(2, 'h1234); idle(3);
    wr(2, 'hFFFF); idle(3);
    wr(2, 'h0000); idle(3);

    // R10: back-pressure and write ordering
    cur_req = "R10";
    wr(0, 'h40); wr(1, 'h00);
    rt_ready = 1'b0;
    acc(64'hA0000, 0);
    acc(64'hB0000, 0);
    wr(0, 'h00);
    acc(64'hA0000, 0);
    idle(2);
    rt_ready = 1'b1;
    idle(1);
    acc(64'hA0000, 0);
    cfg_we = 1'b1; cfg_wsel = 2'd0; cfg_wdata = 16'h0040;
    acc_valid = 1'b1; acc_addr = 32'hA0000; acc_smm = 1'b0;
    tick();
    cfg_we = 1'b0;
    tick();
    acc_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      rt_ready = i[0];
      acc(64'hA0000 + longint'(i), i[1]);
    end
    rt_ready = 1'b1;
    idle(2);

    // R3: lock behaviour, then reset
    cur_req = "R3";
    wr(1, 'h81);
    wr(0, 'h58);
    idle(3);
    wr(0, 'h78); wr(0, 'h40); wr(0, 'h00); wr(0, 'h20);
    wr(1, 'h00); wr(1, 'hFF);
    idle(3);
    acc(64'hA0000, 0); acc(64'hFEDA0000, 0); acc(64'hFEDA0000, 1);
    cur_req = "R1";
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    idle(4);
    cur_req = "R3";
    wr(0, 'h48); idle(3);
    acc(64'hA0000, 0);
    idle(2);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog %s actual=running expected=done", cur_req);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule